// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from a set of peripheral sources and tells a small processor which one to service next. Every source owns a pending flag, an enable bit and a three-bit priority, all reachable through a simple register port. A one-cycle request pulse from a peripheral marks the source pending. Software clears the mark by writing a one to the flag bit. Among the sources that are pending, enabled and hold a non-zero priority, the controller selects the one with the highest priority. When priorities are equal, the source with the lower index wins.

The winner's vector number (index plus a base of 8) and its priority are registered into a status word. The controller raises its request line to the processor whenever that priority is strictly above the current processor level. The processor level is four bits wide. Software owns the lower three bits. The top bit follows a hardware trap input, so software cannot clear it. When the processor acknowledges, the level is raised to the winner's priority. If the nesting-disable control is set, the level is raised to 7 instead, which holds off every further source until software lowers it.

Register map (6-bit word address, 16-bit data): 0x00 control, bit 15 = nesting disable. 0x01 processor level, bits [3:0]. 0x02 status, read-only: vector in bits [6:0] and level in bits [11:8]. 0x10+w holds the flags of sources 16w..16w+15. 0x20+w holds their enables. 0x30+w holds the priorities of sources 4w..4w+3: source 4w+k occupies bits [4k+2:4k]. Reads are combinational.

Top module: `icu_vectored_irq`

## Requirements
- R1: A high bit on `src_set` sets that source's flag at the next clock edge. Writing a 1 to a bit of a flag word clears that flag; writing 0 leaves it unchanged. If a set and a clear reach the same flag in the same cycle, the flag ends up set.
- R2: A source whose enable bit is 0 never appears in the status word, whatever its flag or priority.
- R3: Priority fields are 3 bits at nibble positions within priority words as mapped above. A source with priority 0 never wins.
- R4: Among eligible sources (flag set, enabled, priority non-zero), the highest priority wins. On a tie, the lowest source index wins.
- R5: The status word holds vector 8+index in bits [6:0] and the winner's priority in bits [11:8]. It reads 0 when no source is eligible. It is updated one clock after the flags change.
- R6: `irq_req` is high exactly when the status level is greater than the 4-bit processor level.
- R7: Processor level bits [2:0] take the written value. Bit 3 follows `trap_hold` one clock later, and writes to bit 3 are ignored.
- R8: `irq_ack` while `irq_req` is high loads level bits [2:0] with the winner's priority, or with 7 when control bit 15 is set. An acknowledge while `irq_req` is low leaves the level unchanged, and an acknowledge takes precedence over a same-cycle level write.
- R9: After reset every register reads 0 and `irq_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_set | input | N | Per-source request pulses |
| trap_hold | input | 1 | Trap in progress; drives level bit 3 |
| irq_ack | input | 1 | Processor accepts the current request |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vector | output | 7 | Latched winning vector number |
| irq_level | output | 4 | Latched winning priority |

## Verification
The hardest case to reach from the ports is a request pulse and a software clear landing on the same flag in the same cycle. The bench drives the pulse and a write-one-to-clear on the same falling edge, so both are captured at one rising edge. It mixes in a second flag that only the write clears. The arbitration ordering is covered by pseudo-random sweeps over flags, enables and priorities. Each status word the bench expects is computed from its own scan of those inputs.

// File: rtl/icu_pkg.sv
package icu_pkg;
    localparam int unsigned ICU_DATA_W = 16;
    localparam int unsigned ICU_ADDR_W = 6;
    localparam int unsigned ICU_PRIO_W = 3;
    localparam int unsigned ICU_LVL_W  = 4;
    localparam int unsigned ICU_VEC_W  = 7;

    localparam logic [ICU_ADDR_W-1:0] ADDR_CTRL   = 6'h00;
    localparam logic [ICU_ADDR_W-1:0] ADDR_CPULVL = 6'h01;
    localparam logic [ICU_ADDR_W-1:0] ADDR_STATUS = 6'h02;

    // upper two address bits select a per-source bank
    localparam logic [1:0] BANK_FLAG = 2'b01;
    localparam logic [1:0] BANK_EN   = 2'b10;
    localparam logic [1:0] BANK_PRIO = 2'b11;

    localparam int unsigned CTRL_NEST_BIT = 15;
    localparam logic [ICU_PRIO_W-1:0] PRIO_MAX = 3'd7;

    typedef struct packed {
        logic [ICU_VEC_W-1:0] vec;
        logic [ICU_LVL_W-1:0] lvl;
    } icu_status_t;
endpackage

// File: rtl/icu_src_bank.sv
module icu_src_bank #(
    parameter int unsigned N = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   src_set,
    input  logic [N-1:0]   flag_clr,
    input  logic [N-1:0]   en_wr_mask,
    input  logic [N-1:0]   en_wr_val,
    input  logic [N-1:0]   prio_wr_mask,
    input  logic [3*N-1:0] prio_wr_val,
    output logic [N-1:0]   flag_q,
    output logic [N-1:0]   en_q,
    output logic [3*N-1:0] prio_q
);
    typedef struct packed {
        logic [N-1:0]   flag;
        logic [N-1:0]   en;
        logic [3*N-1:0] prio;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // set overrides clear so no event is lost
        st_d.flag = (st_q.flag & ~flag_clr) | src_set;
        st_d.en   = (st_q.en & ~en_wr_mask) | (en_wr_val & en_wr_mask);
        for (int i = 0; i < int'(N); i++) begin
            if (prio_wr_mask[i]) begin
                st_d.prio[3*i +: 3] = prio_wr_val[3*i +: 3];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_q = st_q.flag;
    assign en_q   = st_q.en;
    assign prio_q = st_q.prio;
endmodule

// File: rtl/icu_arbiter.sv
module icu_arbiter #(
    parameter int unsigned N     = 16,
    parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     flag,
    input  logic [N-1:0]     en,
    input  logic [3*N-1:0]   prio,
    output logic             win_valid,
    output logic [IDX_W-1:0] win_idx,
    output logic [2:0]       win_prio
);
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_prio  = '0;
        // scan high index to low with >=, so the lowest index wins ties
        for (int i = int'(N) - 1; i >= 0; i--) begin
            if (flag[i] && en[i] && (prio[3*i +: 3] != 3'd0) &&
                (prio[3*i +: 3] >= win_prio)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_prio  = prio[3*i +: 3];
            end
        end
    end
endmodule

// File: rtl/icu_vectored_irq.sv
module icu_vectored_irq
    import icu_pkg::*;
#(
    parameter int unsigned N        = 16,
    parameter int unsigned VEC_BASE = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          src_set,
    input  logic                  trap_hold,
    input  logic                  irq_ack,
    input  logic                  reg_we,
    input  logic [ICU_ADDR_W-1:0] reg_addr,
    input  logic [ICU_DATA_W-1:0] reg_wdata,
    output logic [ICU_DATA_W-1:0] reg_rdata,
    output logic                  irq_req,
    output logic [ICU_VEC_W-1:0]  irq_vector,
    output logic [ICU_LVL_W-1:0]  irq_level
);
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic                 nest_off;
        logic [ICU_LVL_W-1:0] cpu_lvl;
        icu_status_t          stat;
    } top_t;

    top_t st_d, st_q;

    logic [N-1:0]   flag_q, en_q;
    logic [3*N-1:0] prio_q;
    logic [N-1:0]   flag_clr, en_wr_mask, en_wr_val, prio_wr_mask;
    logic [3*N-1:0] prio_wr_val;
    logic           win_valid;
    logic [IDX_W-1:0] win_idx;
    logic [2:0]     win_prio;
    logic [1:0]     bank_sel;
    logic [3:0]     word_sel;

    logic                 nest_off_q;
    logic [ICU_LVL_W-1:0] cpu_lvl_q;

    assign bank_sel = reg_addr[5:4];
    assign word_sel = reg_addr[3:0];

    // write decode into per-source masks
    always_comb begin
        flag_clr     = '0;
        en_wr_mask   = '0;
        en_wr_val    = '0;
        prio_wr_mask = '0;
        prio_wr_val  = '0;
        for (int i = 0; i < int'(N); i++) begin
            if (reg_we && bank_sel == BANK_FLAG && word_sel == 4'(i / 16)) begin
                flag_clr[i] = reg_wdata[i % 16];
            end
            if (reg_we && bank_sel == BANK_EN && word_sel == 4'(i / 16)) begin
                en_wr_mask[i] = 1'b1;
                en_wr_val[i]  = reg_wdata[i % 16];
            end
            if (reg_we && bank_sel == BANK_PRIO && word_sel == 4'(i / 4)) begin
                prio_wr_mask[i]      = 1'b1;
                prio_wr_val[3*i +: 3] = reg_wdata[4*(i % 4) +: 3];
            end
        end
    end

    icu_src_bank #(.N(N)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_set      (src_set),
        .flag_clr     (flag_clr),
        .en_wr_mask   (en_wr_mask),
        .en_wr_val    (en_wr_val),
        .prio_wr_mask (prio_wr_mask),
        .prio_wr_val  (prio_wr_val),
        .flag_q       (flag_q),
        .en_q         (en_q),
        .prio_q       (prio_q)
    );

    icu_arbiter #(.N(N), .IDX_W(IDX_W)) u_arb (
        .flag      (flag_q),
        .en        (en_q),
        .prio      (prio_q),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_prio  (win_prio)
    );

    // next-state for control, processor level and latched status
    always_comb begin
        st_d = st_q;
        if (reg_we && reg_addr == ADDR_CTRL) begin
            st_d.nest_off = reg_wdata[CTRL_NEST_BIT];
        end
        st_d.cpu_lvl[3] = trap_hold;
        if (irq_ack && irq_req) begin
            st_d.cpu_lvl[2:0] = st_q.nest_off ? PRIO_MAX : st_q.stat.lvl[2:0];
        end else if (reg_we && reg_addr == ADDR_CPULVL) begin
            st_d.cpu_lvl[2:0] = reg_wdata[2:0];
        end
        if (win_valid) begin
            st_d.stat.vec = ICU_VEC_W'(VEC_BASE) + ICU_VEC_W'(win_idx);
            st_d.stat.lvl = {1'b0, win_prio};
        end else begin
            st_d.stat = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign nest_off_q = st_q.nest_off;
    assign cpu_lvl_q  = st_q.cpu_lvl;
    assign irq_req    = st_q.stat.lvl > st_q.cpu_lvl;
    assign irq_vector = st_q.stat.vec;
    assign irq_level  = st_q.stat.lvl;

    // read mux
    always_comb begin
        reg_rdata = '0;
        unique case (bank_sel)
            2'b00: begin
                if (reg_addr == ADDR_CTRL) begin
                    reg_rdata[CTRL_NEST_BIT] = st_q.nest_off;
                end else if (reg_addr == ADDR_CPULVL) begin
                    reg_rdata[3:0] = st_q.cpu_lvl;
                end else if (reg_addr == ADDR_STATUS) begin
                    reg_rdata[6:0]  = st_q.stat.vec;
                    reg_rdata[11:8] = st_q.stat.lvl;
                end
            end
            BANK_FLAG: begin
                for (int i = 0; i < int'(N); i++) begin
                    if (word_sel == 4'(i / 16)) reg_rdata[i % 16] = flag_q[i];
                end
            end
            BANK_EN: begin
                for (int i = 0; i < int'(N); i++) begin
                    if (word_sel == 4'(i / 16)) reg_rdata[i % 16] = en_q[i];
                end
            end
            default: begin
                for (int i = 0; i < int'(N); i++) begin
                    if (word_sel == 4'(i / 4)) reg_rdata[4*(i % 4) +: 3] = prio_q[3*i +: 3];
                end
            end
        endcase
    end
endmodule

// File: rtl/icu_vectored_irq_chk.sv
module icu_vectored_irq_chk #(
    parameter int unsigned N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] src_set,
    input logic [N-1:0] flag_q,
    input logic         trap_hold,
    input logic         irq_ack,
    input logic         irq_req,
    input logic         nest_off_q,
    input logic [3:0]   cpu_lvl_q,
    input logic [3:0]   irq_level,
    input logic [6:0]   irq_vector
);
    a_r1_set_reaches_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (src_set != '0) |=> ((flag_q & $past(src_set)) == $past(src_set)));

    a_r5_idle_status_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level == 4'd0) |-> (irq_vector == 7'd0));

    a_r6_req_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_level != 4'd0));

    a_r7_trap_bit_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cpu_lvl_q[3] == $past(trap_hold)));

    a_r8_ack_nest_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req && nest_off_q) |=> (cpu_lvl_q[2:0] == 3'd7));

    a_r8_ack_takes_level: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req && !nest_off_q) |=> (cpu_lvl_q[2:0] == $past(irq_level[2:0])));
endmodule

bind icu_vectored_irq icu_vectored_irq_chk #(.N(N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_set    (src_set),
    .flag_q     (flag_q),
    .trap_hold  (trap_hold),
    .irq_ack    (irq_ack),
    .irq_req    (irq_req),
    .nest_off_q (nest_off_q),
    .cpu_lvl_q  (cpu_lvl_q),
    .irq_level  (irq_level),
    .irq_vector (irq_vector)
);

// File: tb/icu_vectored_irq_test.sv
module icu_vectored_irq_test;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_set = '0;
    logic          trap_hold = 1'b0;
    logic          irq_ack = 1'b0;
    logic          reg_we = 1'b0;
    logic [5:0]    reg_addr = '0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic          irq_req;
    logic [6:0]    irq_vector;
    logic [3:0]    irq_level;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    icu_vectored_irq #(.N(NS), .VEC_BASE(8)) uut (
        .clk(clk), .rst_n(rst_n), .src_set(src_set), .trap_hold(trap_hold),
        .irq_ack(irq_ack), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
        .irq_vector(irq_vector), .irq_level(irq_level)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input logic [NS-1:0] m);
        @(negedge clk);
        src_set = m;
        @(negedge clk);
        src_set = '0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic ack();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    // expected status word, from the requirements
    function automatic logic [15:0] model(input logic [15:0] f, input logic [15:0] e,
                                          input logic [63:0] pw);
        int best = 0;
        int idx = 0;
        for (int i = 0; i < NS; i++) begin
            int p = int'(pw[16*(i/4) + 4*(i%4) +: 3]);
            if (f[i] && e[i] && p > best) begin
                best = p;
                idx = i;
            end
        end
        if (best == 0) return 16'h0;
        return 16'((best << 8) | (8 + idx));
    endfunction

    task automatic write_prios(input logic [63:0] pw);
        for (int w = 0; w < 4; w++) wr(6'h30 + 6'(w), pw[16*w +: 16]);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [63:0] pw;
        logic [31:0] s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        rd(6'h00, d); check("R9 ctrl", d, 0);
        rd(6'h01, d); check("R9 cpulvl", d, 0);
        rd(6'h02, d); check("R9 status", d, 0);
        rd(6'h10, d); check("R9 flags", d, 0);
        rd(6'h20, d); check("R9 enables", d, 0);
        rd(6'h33, d); check("R9 prio3", d, 0);
        check("R9 irq_req", irq_req, 0);

        // single-source sweep: R1 R3 R5 R6
        pw = '0;
        for (int i = 0; i < NS; i++) pw[16*(i/4) + 4*(i%4) +: 3] = 3'((i % 7) + 1);
        write_prios(pw);
        rd(6'h31, d); check("R3 prio word1 readback", d, pw[31:16]);
        wr(6'h20, 16'hFFFF);
        for (int i = 0; i < NS; i++) begin
            pulse(16'(1) << i);
            settle();
            rd(6'h10, d); check("R1 flag set", d, 16'(1) << i);
            rd(6'h02, d); check("R5 status single", d, 16'((((i % 7) + 1) << 8) | (8 + i)));
            check("R5 irq_vector", irq_vector, 7'(8 + i));
            check("R6 req vs level 0", irq_req, 1);
            wr(6'h10, 16'(1) << i);
            settle();
            rd(6'h10, d); check("R1 flag cleared", d, 0);
            rd(6'h02, d); check("R5 status idle", d, 0);
        end

        // pseudo-random sweep: R2 R3 R4
        s = 32'h1234_5678;
        for (int t = 0; t < 48; t++) begin
            logic [15:0] f, e;
            s ^= s << 13; s ^= s >> 17; s ^= s << 5;
            f = s[15:0];
            e = s[31:16] | 16'(t);
            s ^= s << 13; s ^= s >> 17; s ^= s << 5;
            pw[31:0] = s;
            s ^= s << 13; s ^= s >> 17; s ^= s << 5;
            pw[63:32] = s;
            for (int k = 0; k < 16; k++) pw[4*k + 3] = 1'b0;
            wr(6'h10, 16'hFFFF);
            wr(6'h20, e);
            write_prios(pw);
            pulse(f);
            settle();
            rd(6'h02, d); check("R4 R2 R3 random arbitration", d, model(f, e, pw));
        end

        // tie-break: R4
        wr(6'h10, 16'hFFFF);
        wr(6'h20, 16'hFFFF);
        write_prios({16{4'h5}});
        pulse(16'hFFFF);
        settle();
        for (int k = 0; k < NS; k++) begin
            rd(6'h02, d); check("R4 tie lowest index", d, 16'((5 << 8) | (8 + k)));
            wr(6'h10, 16'(1) << k);
            settle();
        end
        rd(6'h02, d); check("R4 tie all cleared", d, 0);

        // priority 0 and disabled: R3 R2
        write_prios(64'h0000_0000_0000_0070);
        wr(6'h20, 16'hFFFD);
        pulse(16'h0003);
        settle();
        rd(6'h02, d); check("R3 prio0 excluded, R2 disabled excluded", d, 0);
        wr(6'h20, 16'hFFFF);
        settle();
        rd(6'h02, d); check("R2 enable restores", d, 16'h0709);

        // level sweep: R6 R7
        wr(6'h10, 16'hFFFF);
        write_prios(64'h0000_0000_0000_4000);
        pulse(16'h0008);
        settle();
        for (int l = 0; l < 8; l++) begin
            wr(6'h01, 16'(l));
            rd(6'h01, d); check("R7 level write", d, 16'(l));
            check("R6 req compare", irq_req, (4 > l) ? 1 : 0);
        end

        // trap bit: R7
        wr(6'h01, 16'h0000);
        write_prios(64'h0000_0000_0000_7000);
        @(negedge clk) trap_hold = 1'b1;
        settle();
        rd(6'h01, d); check("R7 trap sets bit3", d, 16'h0008);
        check("R6 trap blocks prio7", irq_req, 0);
        @(negedge clk) trap_hold = 1'b0;
        wr(6'h01, 16'h000F);
        rd(6'h01, d); check("R7 bit3 not writable", d, 16'h0007);

        // acknowledge: R8
        write_prios(64'h0000_0000_0000_4000);
        wr(6'h00, 16'h0000);
        wr(6'h01, 16'h0000);
        check("R8 req before ack", irq_req, 1);
        ack();
        rd(6'h01, d); check("R8 ack loads priority", d, 16'h0004);
        check("R8 req dropped after ack", irq_req, 0);
        wr(6'h00, 16'h8000);
        rd(6'h00, d); check("R8 nest control readback", d, 16'h8000);
        wr(6'h01, 16'h0000);
        ack();
        rd(6'h01, d); check("R8 nest-off forces 7", d, 16'h0007);
        wr(6'h01, 16'h0005);
        ack();
        rd(6'h01, d); check("R8 ack without req ignored", d, 16'h0005);

        // same-cycle set and clear: R1
        wr(6'h10, 16'hFFFF);
        pulse(16'h000C);
        @(negedge clk);
        src_set = 16'h0004;
        reg_we = 1'b1; reg_addr = 6'h10; reg_wdata = 16'h000C;
        @(negedge clk);
        src_set = '0; reg_we = 1'b0;
        rd(6'h10, d); check("R1 set wins over clear", d, 16'h0004);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule